// File: doc/BRIEF.md
# Qualified-Storage Capture Engine

This block is an on-chip logic analyzer core. On every edge of one free-running sample clock it looks at a small probe bus and a wider data bus. Two identical match units evaluate the probe bits. The first match unit is the storage qualifier: it acts as a write enable, and a data sample enters the circular buffer only on cycles where its condition holds. The second match unit is the trigger. For each probe bit, a match unit can ask for a high level, a low level, a rising edge or a falling edge, or it can ignore the bit. An edge is found by comparing the present sample with the sample taken on the cycle before. The sample clock is never looked at as data.

Software arms the engine and gives it a trigger position P. This is the number of qualified samples kept from before the trigger. The engine accepts a trigger only after at least P pre-trigger samples have been stored. It then stores DEPTH−P more qualified samples, counting a write on the trigger cycle itself. After that the capture is complete and the buffer is full. Only then does a valid/ready stream hand out all DEPTH entries, oldest first. The trigger sample sits at readout position P. The stream obeys normal back-pressure rules. rd_data and rd_last hold steady while rd_valid is high and rd_ready is low. An entry leaves the stream only on a cycle where rd_valid and rd_ready are both high. A force-trigger pulse fires the trigger one cycle later without regard to the trigger match.

Top module: `lac_capture`

## Requirements
- R1: After reset, armed, triggered, full and rd_valid are all low.
- R2: A cycle with arm high clears triggered and full, restarts storage at an empty buffer, latches trig_pos, and makes armed high from the next cycle.
- R3: The match configuration gives 3 bits to probe bit i, at cfg[3i+2:3i]. The codes are: 0 ignore, 1 high, 2 low, 3 rising (0 on the previous cycle, 1 now), 4 falling (1 on the previous cycle, 0 now). Codes 5 to 7 also ignore the bit. A unit matches when every bit it does not ignore matches, so a unit that ignores every bit always matches.
- R4: A data sample is written only on a cycle where armed is high and the qualifier matches. The value written is data_in of that same cycle.
- R5: While armed and not yet triggered, the trigger is accepted on a cycle where the trigger unit matches and at least the latched position's worth of samples has been stored. triggered is high from the next cycle.
- R6: A force_trig pulse while armed causes the trigger on the following cycle whatever the trigger match shows. The force stays pending until the trigger is accepted under the fill rule of R5.
- R7: Counting a write on the trigger cycle, once DEPTH−P samples have been written after the trigger, full goes high and armed goes low. Qualified cycles after that write nothing.
- R8: rd_valid is high only while full is high. The stream delivers exactly DEPTH entries, oldest first. rd_data holds while stalled, rd_last marks the final entry, and rd_valid then stays low until the next arm.
- R9: From the trigger until the next arm, trig_index equals the latched position P, which is the readout position of the first sample stored on or after the trigger cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | DATA_W | Data bus being captured |
| probe_in | input | PROBE_W | Bits watched by both match units |
| qual_cfg | input | 3*PROBE_W | Storage qualifier condition codes |
| trig_cfg | input | 3*PROBE_W | Trigger condition codes |
| trig_pos | input | $clog2(DEPTH) | Pre-trigger sample count, latched at arm |
| arm | input | 1 | Start a new capture |
| force_trig | input | 1 | Force the trigger on the next cycle |
| armed | output | 1 | Capture in progress |
| triggered | output | 1 | Trigger accepted since the last arm |
| full | output | 1 | Capture complete, buffer readable |
| trig_index | output | $clog2(DEPTH) | Readout position of the trigger sample |
| rd_valid | output | 1 | Readout entry available |
| rd_ready | input | 1 | Consumer accepts the entry |
| rd_data | output | DATA_W | Readout entry |
| rd_last | output | 1 | Final entry of the buffer |

## Verification
The bench targets the edge qualifier with a probe held high across several cycles. A design that treats the code as a level would fill the buffer with the filler values placed between pulses. It also raises the trigger condition right after arming with a large position. A design that ignores the pre-fill rule would trigger early and move the trigger sample away from readout position P. The falling-edge trigger is combined with a level condition on another bit, so a falling edge alone must not fire. Readout runs under an irregular rd_ready pattern, which would expose an off-by-one start address, data that changes during a stall, or a misplaced rd_last. A run with one write per cycle checks exactly when full rises, which would show an error in the post-trigger count.

// File: rtl/lac_pkg.sv
package lac_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    MC_ANY  = 3'd0,
    MC_HIGH = 3'd1,
    MC_LOW  = 3'd2,
    MC_RISE = 3'd3,
    MC_FALL = 3'd4
  } match_code_e;

  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_PRE,
    CAP_POST,
    CAP_DONE
  } cap_state_e;

  // One probe bit against one condition code; edges need a valid prior sample.
  function automatic logic bit_hit(input logic [CODE_W-1:0] code,
                                   input logic cur,
                                   input logic prv,
                                   input logic prv_ok);
    logic r;
    case (code)
      MC_HIGH: r = cur;
      MC_LOW:  r = ~cur;
      MC_RISE: r = prv_ok & ~prv & cur;
      MC_FALL: r = prv_ok & prv & ~cur;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lac_history.sv
module lac_history #(
  parameter int PROBE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_in,
  output logic [PROBE_W-1:0] prv,
  output logic               prv_ok
);

  // Previous-cycle copy of the probes, used for edge tests.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv    <= '0;
      prv_ok <= 1'b0;
    end else begin
      prv    <= probe_in;
      prv_ok <= 1'b1;
    end
  end

endmodule

// File: rtl/lac_match.sv
module lac_match
  import lac_pkg::*;
#(
  parameter int PROBE_W = 4
) (
  input  logic [PROBE_W-1:0]        cur,
  input  logic [PROBE_W-1:0]        prv,
  input  logic                      prv_ok,
  input  logic [CODE_W*PROBE_W-1:0] cfg,
  output logic                      hit
);

  logic [PROBE_W-1:0] per_bit;

  for (genvar g = 0; g < PROBE_W; g++) begin : g_bit
    assign per_bit[g] = bit_hit(cfg[CODE_W*g +: CODE_W], cur[g], prv[g], prv_ok);
  end

  // Ignored bits report 1, so the AND covers only the bits that are tested.
  assign hit = &per_bit;

endmodule

// File: rtl/lac_ctrl.sv
module lac_ctrl
  import lac_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic                     force_trig,
  input  logic [$clog2(DEPTH)-1:0] trig_pos,
  input  logic                     qual_hit,
  input  logic                     trig_hit,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [$clog2(DEPTH)-1:0] oldest,
  output logic                     armed,
  output logic                     triggered,
  output logic                     full,
  output logic [$clog2(DEPTH)-1:0] trig_index
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);

  cap_state_e    state;
  logic [AW-1:0] wptr;
  logic [AW-1:0] pos_q;
  logic [CW-1:0] pre_cnt;
  logic [CW-1:0] post_cnt;
  logic [CW-1:0] post_need;
  logic          force_pend;
  logic [AW-1:0] tidx_q;
  logic          capturing;
  logic          accept;
  logic          done_now;

  assign capturing = (state == CAP_PRE) || (state == CAP_POST);
  assign wr_en     = capturing && qual_hit && !arm;
  assign post_need = DEPTH_C - {1'b0, pos_q};
  assign accept    = (state == CAP_PRE) && !arm && (trig_hit || force_pend)
                     && (pre_cnt >= {1'b0, pos_q});

  // The write that completes the post-trigger window, including on the trigger cycle.
  always_comb begin
    done_now = 1'b0;
    if (wr_en) begin
      if (accept)
        done_now = (post_need == CW'(1));
      else if (state == CAP_POST)
        done_now = (post_cnt + CW'(1) == post_need);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CAP_IDLE;
      wptr       <= '0;
      pos_q      <= '0;
      pre_cnt    <= '0;
      post_cnt   <= '0;
      force_pend <= 1'b0;
      tidx_q     <= '0;
    end else if (arm) begin
      state      <= CAP_PRE;
      wptr       <= '0;
      pos_q      <= trig_pos;
      pre_cnt    <= '0;
      post_cnt   <= '0;
      force_pend <= 1'b0;
      tidx_q     <= '0;
    end else begin
      if (wr_en)
        wptr <= (wptr == LAST_A) ? '0 : wptr + AW'(1);
      case (state)
        CAP_PRE: begin
          if (accept) begin
            force_pend <= 1'b0;
            tidx_q     <= pos_q;
            post_cnt   <= wr_en ? CW'(1) : '0;
            state      <= done_now ? CAP_DONE : CAP_POST;
          end else begin
            if (force_trig)
              force_pend <= 1'b1;
            if (wr_en && pre_cnt != DEPTH_C)
              pre_cnt <= pre_cnt + CW'(1);
          end
        end
        CAP_POST: begin
          if (wr_en)
            post_cnt <= post_cnt + CW'(1);
          if (done_now)
            state <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  assign wr_addr    = wptr;
  assign oldest     = wptr;
  assign armed      = capturing;
  assign triggered  = (state == CAP_POST) || (state == CAP_DONE);
  assign full       = (state == CAP_DONE);
  assign trig_index = tidx_q;

endmodule

// File: rtl/lac_store.sv
module lac_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     full,
  input  logic [$clog2(DEPTH)-1:0] oldest,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_last
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_cnt;
  logic              rd_done;
  logic [AW:0]       addr_sum;
  logic [AW-1:0]     rd_addr;

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
  end

  // Readout position rd_cnt counts from the oldest entry and wraps at DEPTH.
  always_comb begin
    addr_sum = {1'b0, oldest} + {1'b0, rd_cnt};
    if (addr_sum >= DEPTH_C)
      addr_sum = addr_sum - DEPTH_C;
    rd_addr = addr_sum[AW-1:0];
  end

  assign rd_valid = full && !rd_done;
  assign rd_data  = mem[rd_addr];
  assign rd_last  = rd_valid && (rd_cnt == LAST_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      rd_done <= 1'b0;
    end else if (arm) begin
      rd_cnt  <= '0;
      rd_done <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      if (rd_last)
        rd_done <= 1'b1;
      else
        rd_cnt <= rd_cnt + AW'(1);
    end
  end

endmodule

// File: rtl/lac_capture.sv
module lac_capture
  import lac_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PROBE_W = 4,
  parameter int DEPTH   = 1024
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           data_in,
  input  logic [PROBE_W-1:0]          probe_in,
  input  logic [CODE_W*PROBE_W-1:0]   qual_cfg,
  input  logic [CODE_W*PROBE_W-1:0]   trig_cfg,
  input  logic [$clog2(DEPTH)-1:0]    trig_pos,
  input  logic                        arm,
  input  logic                        force_trig,
  output logic                        armed,
  output logic                        triggered,
  output logic                        full,
  output logic [$clog2(DEPTH)-1:0]    trig_index,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_last
);

  localparam int AW = $clog2(DEPTH);

  logic [PROBE_W-1:0] prv;
  logic               prv_ok;
  logic               qual_hit;
  logic               trig_hit;
  logic               wr_en;
  logic [AW-1:0]      wr_addr;
  logic [AW-1:0]      oldest;

  lac_history #(.PROBE_W(PROBE_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .prv(prv), .prv_ok(prv_ok)
  );

  lac_match #(.PROBE_W(PROBE_W)) u_qual (
    .cur(probe_in), .prv(prv), .prv_ok(prv_ok), .cfg(qual_cfg), .hit(qual_hit)
  );

  lac_match #(.PROBE_W(PROBE_W)) u_trig (
    .cur(probe_in), .prv(prv), .prv_ok(prv_ok), .cfg(trig_cfg), .hit(trig_hit)
  );

  lac_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .force_trig(force_trig),
    .trig_pos(trig_pos), .qual_hit(qual_hit), .trig_hit(trig_hit),
    .wr_en(wr_en), .wr_addr(wr_addr), .oldest(oldest),
    .armed(armed), .triggered(triggered), .full(full), .trig_index(trig_index)
  );

  lac_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(data_in), .full(full), .oldest(oldest), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

endmodule

// File: rtl/lac_capture_chk.sv
module lac_capture_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              rd_ready,
  input logic              armed,
  input logic              triggered,
  input logic              full,
  input logic [IDX_W-1:0]  trig_index,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_last
);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed && !triggered && !full));

  assert_trig_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(triggered) |-> $past(arm));

  assert_full_after_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(armed));

  assert_full_needs_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> triggered);

  assert_no_read_before_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> full);

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !arm) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

  assert_last_in_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  assert_index_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> $stable(trig_index));

endmodule

bind lac_capture lac_capture_chk #(.DATA_W(DATA_W), .IDX_W($clog2(DEPTH))) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .rd_ready(rd_ready), .armed(armed),
  .triggered(triggered), .full(full), .trig_index(trig_index),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
);

// File: tb/sim_lac_capture.sv
`timescale 1ns/1ps
module sim_lac_capture;

  localparam int DW  = 8;
  localparam int PW  = 4;
  localparam int DEP = 16;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [PW-1:0] probe_in = '0;
  logic [3*PW-1:0] qual_cfg = '0;
  logic [3*PW-1:0] trig_cfg = '0;
  logic [IW-1:0] trig_pos = '0;
  logic          arm = 1'b0;
  logic          force_trig = 1'b0;
  logic          armed, triggered, full, rd_valid, rd_last;
  logic          rd_ready = 1'b0;
  logic [IW-1:0] trig_index;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [DW-1:0] expv [DEP];

  always #5 clk = ~clk;

  lac_capture #(.DATA_W(DW), .PROBE_W(PW), .DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .probe_in(probe_in),
    .qual_cfg(qual_cfg), .trig_cfg(trig_cfg), .trig_pos(trig_pos),
    .arm(arm), .force_trig(force_trig), .armed(armed), .triggered(triggered),
    .full(full), .trig_index(trig_index), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_arm(input logic [IW-1:0] pos);
    trig_pos = pos;
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk("R2 armed after arm", armed, 1);
    chk("R2 triggered cleared", triggered, 0);
    chk("R2 full cleared", full, 0);
  endtask

  task automatic read_all(input string tag);
    int got = 0;
    int guard = 0;
    chk({tag, " R8 valid when full"}, rd_valid, 1);
    while (got < DEP && guard < 200) begin
      rd_ready = (guard % 3 != 1);
      if (rd_valid && rd_ready) begin
        chk($sformatf("%s R8 entry %0d", tag, got), rd_data, expv[got]);
        chk($sformatf("%s R8 last flag %0d", tag, got), rd_last, (got == DEP-1));
        got++;
      end
      guard++;
      step();
    end
    rd_ready = 1'b0;
    chk({tag, " R8 entry count"}, got, DEP);
    chk({tag, " R8 valid drops after last"}, rd_valid, 0);
  endtask

  // R1: reset state
  task automatic t_reset();
    chk("R1 armed", armed, 0);
    chk("R1 triggered", triggered, 0);
    chk("R1 full", full, 0);
    chk("R1 rd_valid", rd_valid, 0);
  endtask

  // R3 high level trigger, R4 store every cycle, R7 full timing, R9 index
  task automatic t_level();
    logic [DW-1:0] v;
    qual_cfg = '0;
    trig_cfg = 12'h001;
    probe_in = '0;
    do_arm(4'd4);
    for (int c = 0; c < 10; c++) begin
      data_in = 8'h10 + DW'(c);
      step();
    end
    chk("R5 no trigger before match", triggered, 0);
    chk("R8 no readout while capturing", rd_valid, 0);
    v = 8'h1A;
    data_in = v;
    probe_in[0] = 1'b1;
    step();
    probe_in[0] = 1'b0;
    chk("R5 triggered after high match", triggered, 1);
    chk("R9 trig_index", trig_index, 4);
    for (int k = 1; k <= 11; k++) begin
      data_in = v + DW'(k);
      step();
      if (k == 10) chk("R7 not full one write early", full, 0);
      if (k == 11) chk("R7 full after window", full, 1);
    end
    chk("R7 armed low when full", armed, 0);
    for (int k = 12; k < 20; k++) begin
      data_in = v + DW'(k);
      step();
    end
    for (int i = 0; i < DEP; i++) expv[i] = v - 8'd4 + DW'(i);
    read_all("level");
  endtask

  // R3 rising qualifier, R4 same-cycle data, R6 force
  task automatic t_rise_force();
    qual_cfg = 12'h018;
    trig_cfg = 12'h001;
    probe_in = '0;
    do_arm(4'd2);
    for (int i = 0; i < 22; i++) begin
      if (i == 5) begin
        force_trig = 1'b1;
        step();
        force_trig = 1'b0;
        chk("R6 not triggered in force cycle", triggered, 0);
        step();
        chk("R6 triggered one cycle later", triggered, 1);
      end
      probe_in[1] = 1'b1; data_in = 8'h40 + DW'(i); step();
      probe_in[1] = 1'b1; data_in = 8'hEE; step();
      probe_in[1] = 1'b0; step();
      step();
    end
    chk("R9 trig_index force", trig_index, 2);
    for (int i = 0; i < DEP; i++) expv[i] = 8'h43 + DW'(i);
    read_all("rise");
  endtask

  // R3 falling edge combined with high level on another bit
  task automatic t_fall_and();
    logic [DW-1:0] d;
    qual_cfg = '0;
    trig_cfg = 12'h300;
    probe_in = 4'b0100;
    d = 8'h60;
    do_arm(4'd8);
    for (int c = 0; c < 10; c++) begin data_in = d; d++; step(); end
    probe_in = 4'b0000; data_in = d; d++; step();
    chk("R3 fall without level partner ignored", triggered, 0);
    probe_in = 4'b0100; data_in = d; d++; step();
    probe_in = 4'b1100; data_in = d; d++; step();
    chk("R3 level alone no trigger", triggered, 0);
    probe_in = 4'b1000; data_in = d;
    for (int i = 0; i < DEP; i++) expv[i] = d - 8'd8 + DW'(i);
    d++; step();
    chk("R3 fall with level triggers", triggered, 1);
    for (int c = 0; c < 12; c++) begin data_in = d; d++; step(); end
    chk("R7 full fall case", full, 1);
    read_all("fall");
  endtask

  // R5 pre-fill rule, R3 low-level qualifier
  task automatic t_prefill();
    logic [DW-1:0] d;
    qual_cfg = 12'h400;
    trig_cfg = 12'h001;
    probe_in = 4'b0001;
    d = 8'h80;
    data_in = d;
    do_arm(4'd10);
    for (int c = 0; c < 60; c++) begin
      d++;
      data_in = d;
      probe_in[3] = d[0];
      step();
      if (c == 4) chk("R5 trigger held until prefill", triggered, 0);
    end
    chk("R7 full prefill case", full, 1);
    chk("R9 trig_index prefill", trig_index, 10);
    for (int i = 0; i < DEP; i++) expv[i] = 8'h82 + DW'(2*i);
    read_all("prefill");
  endtask

  // R2 re-arm mid capture clears trigger
  task automatic t_rearm();
    qual_cfg = '0;
    trig_cfg = 12'h001;
    probe_in = 4'b0001;
    do_arm(4'd0);
    step();
    chk("R5 triggered before rearm", triggered, 1);
    probe_in = '0;
    do_arm(4'd3);
    step();
    chk("R2 rearm keeps triggered low", triggered, 0);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog R1 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_level();
    t_rise_force();
    t_fall_and();
    t_prefill();
    t_rearm();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule